// File: doc/BRIEF.md
# Programmable Chip Select Controller

This block watches the transfers that a bus master starts on an external bus and decides which of a small set of external memory or peripheral devices the transfer addresses. For the winning device it drives an active-low chip-select strobe and, on writes, active-low per-byte write strobes. Each select line has its own base, mask and control register. Together these set the address window, which directions and transfer kinds the line refuses, and the strobe timing. The timing options are asserting in the start clock or one clock later, one extra hold clock after the transfer ends, and whether the strobe stays low through the beats of a burst.

After reset, select line 0 acts as a boot select. It answers every normal external transfer, whatever address is presented, so that a boot memory can sit anywhere. It stays in this mode while its control register is rewritten. The first write to its mask register ends boot mode, and only a reset brings it back. The port-size and auto-acknowledge setting for the boot device is taken from three configuration pins on the final clock edge of reset.

A burst is a fixed number of beats, each ended by the terminate strobe. A start is accepted only while the controller is idle. A start that matches no line leaves every strobe high.

Top module: `chip_select_ctrl`

## Requirements
- R1: While reset is low and right after it, every chip-select and write-enable output is high and `addr_hold` is 0. Control register 0 reads 0x0F (enable, setup, read hold, write hold set; burst keep clear). All other registers read 0.
- R2: Outside boot mode, line i matches when its control bit 0 (enable) is set and ((addr XOR base) AND NOT mask[ADDR_W-1:0]) is zero. A match is refused when a mask bit at ADDR_W+0 (refuse writes), ADDR_W+1 (refuse reads), ADDR_W+2 (refuse kind 01, CPU space) or ADDR_W+3 (refuse kind 10, internal) applies. Kind 00 is a normal transfer. When no line matches, no strobe asserts and terminate pulses are ignored.
- R3: When several lines match, only the lowest-numbered one asserts. At most one chip select is low at any time.
- R4: With control bit 1 (setup) clear, the chip select goes low in the clock where `xfer_start` is high. With it set, the chip select goes low in the next clock. It stays low through the clock where the last `xfer_done` is high.
- R5: Write enables go low only on writes, only for lanes whose `xfer_lanes` bit is 1, and only from the second consecutive clock of chip-select assertion until the transfer ends. They are high during a hold clock.
- R6: When control bit 2 (read hold) is set for a read, or bit 3 (write hold) for a write, one extra clock follows the final terminate. In that clock the chip select stays low and `addr_hold` is 1.
- R7: With `xfer_burst` high, a transfer lasts BURST_BEATS terminate pulses. With control bit 4 (burst keep) set, the chip select stays low between beats. With it clear, the chip select goes high for exactly one clock after each non-final terminate, then goes low again.
- R8: In boot mode, line 0 matches every kind-00 transfer regardless of its base and mask, and never matches kind 01 or kind 10.
- R9: Writing control register 0 keeps boot mode. The first write to mask register 0 ends boot mode. A reset restores it.
- R10: `boot_port_size` = pins[1:0] and `boot_auto_ack` = pins[2], as sampled on the last rising clock edge with `rst_n` low. Later pin changes have no effect.
- R11: Register select 0 is base, 1 is mask and 2 is control, indexed by `reg_idx`. A read returns the stored value on `reg_rdata` in the clock after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_cfg_pins | input | 3 | Boot configuration pins, sampled during reset |
| xfer_start | input | 1 | Transfer start strobe, one clock |
| xfer_addr | input | ADDR_W | Transfer address, held for the whole transfer |
| xfer_write | input | 1 | 1 = write, 0 = read |
| xfer_kind | input | 2 | 00 normal, 01 CPU space, 10 internal |
| xfer_burst | input | 1 | Burst transfer of BURST_BEATS beats |
| xfer_lanes | input | LANE_W | Active byte lanes |
| xfer_done | input | 1 | Beat terminate strobe |
| reg_wr | input | 1 | Register write |
| reg_rd | input | 1 | Register read |
| reg_idx | input | IDX_W | Chip-select index |
| reg_sel | input | 2 | 0 base, 1 mask, 2 control |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, one clock after reg_rd |
| cs_n | output | NUM_CS | Active-low chip selects |
| we_n | output | LANE_W | Active-low byte write enables |
| addr_hold | output | 1 | High in the extra hold clock |
| boot_port_size | output | 2 | Captured boot port size |
| boot_auto_ack | output | 1 | Captured boot auto-acknowledge |

## Verification
The final terminate of a burst can land in the same clock where the hold extension begins, and the burst gap decision can meet the setup choice of the next beat. The bench sweeps all sixteen settings of setup, read hold, write hold and burst keep on one line, for reads and writes, single and burst. Its cycle model predicts every clock of every strobe, so a chip select that negates too early, skips its gap or overlaps the hold clock is caught. Decode priority and boot-mode exit are judged the same way, with a sweep of all sixteen address pages against overlapping windows.

// File: rtl/csc_pkg.sv
// Shared types for the chip select controller.
// Assumes: control register fields sit in the low five bits.
package csc_pkg;

    // Transfer kind codes on xfer_kind
    localparam logic [1:0] KIND_NORMAL   = 2'b00;
    localparam logic [1:0] KIND_CPU      = 2'b01;
    localparam logic [1:0] KIND_INTERNAL = 2'b10;

    // Register select codes on reg_sel
    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    // Mask register refuse-bit offsets above the address mask
    localparam int MB_NO_WRITE = 0;
    localparam int MB_NO_READ  = 1;
    localparam int MB_NO_CPU   = 2;
    localparam int MB_NO_INT   = 3;
    localparam int MB_COUNT    = 4;

    // Per-line control fields, bit 0 is enable
    typedef struct packed {
        logic keep;     // bit 4: hold select low across burst beats
        logic wr_hold;  // bit 3: extra clock after write
        logic rd_hold;  // bit 2: extra clock after read
        logic setup;    // bit 1: assert one clock after start
        logic enable;   // bit 0: line enabled
    } cs_ctrl_t;

    localparam int CTRL_W = $bits(cs_ctrl_t);

    // Boot line reset control: enable, setup, read hold, write hold
    localparam cs_ctrl_t CTRL_BOOT_RST = '{keep: 1'b0, wr_hold: 1'b1, rd_hold: 1'b1,
                                           setup: 1'b1, enable: 1'b1};

    // Transfer sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/csc_regs.sv
// Register file: base, mask and control per line, boot mode flag,
// boot configuration capture. Assumes one register access per clock.
module csc_regs
    import csc_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 28,
    parameter int IDX_W  = 2,
    parameter int REG_W  = ADDR_W + MB_COUNT
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    boot_cfg_pins,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [IDX_W-1:0]              reg_idx,
    input  logic [1:0]                    reg_sel,
    input  logic [REG_W-1:0]              reg_wdata,
    output logic [REG_W-1:0]              reg_rdata,
    output logic [NUM_CS-1:0][ADDR_W-1:0] base_o,
    output logic [NUM_CS-1:0][REG_W-1:0]  mask_o,
    output cs_ctrl_t [NUM_CS-1:0]         ctrl_o,
    output logic                          boot_mode_o,
    output logic [2:0]                    boot_cfg_o
);

    logic [REG_W-1:0] rd_mux;

    // Per-line registers
    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        localparam cs_ctrl_t CTRL_RST = (g == 0) ? CTRL_BOOT_RST : cs_ctrl_t'('0);
        logic hit_idx;
        assign hit_idx = reg_wr && (reg_idx == IDX_W'(g));

        // Store base, mask and control on an indexed write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[g] <= '0;
                mask_o[g] <= '0;
                ctrl_o[g] <= CTRL_RST;
            end else if (hit_idx) begin
                case (reg_sel)
                    SEL_BASE: base_o[g] <= reg_wdata[ADDR_W-1:0];
                    SEL_MASK: mask_o[g] <= reg_wdata;
                    SEL_CTRL: ctrl_o[g] <= cs_ctrl_t'(reg_wdata[CTRL_W-1:0]);
                    default:  ;
                endcase
            end
        end
    end

    // Boot mode ends on the first write to mask register 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_mode_o <= 1'b1;
        end else if (reg_wr && reg_idx == '0 && reg_sel == SEL_MASK) begin
            boot_mode_o <= 1'b0;
        end
    end

    // Capture boot pins on every clock of reset; the last one stays
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_cfg_o <= boot_cfg_pins;
        end
    end

    // Select the addressed register for read-back
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (reg_idx == IDX_W'(i)) begin
                case (reg_sel)
                    SEL_BASE: rd_mux = REG_W'(base_o[i]);
                    SEL_MASK: rd_mux = mask_o[i];
                    SEL_CTRL: rd_mux = REG_W'(ctrl_o[i]);
                    default:  rd_mux = '0;
                endcase
            end
        end
    end

    // Register the read data one clock after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/csc_decode.sv
// Address, direction and kind decode with lowest-index priority.
// Assumes the transfer attributes are valid whenever start is high.
module csc_decode
    import csc_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 28,
    parameter int REG_W  = ADDR_W + MB_COUNT
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          write,
    input  logic [1:0]                    kind,
    input  logic [NUM_CS-1:0][ADDR_W-1:0] base,
    input  logic [NUM_CS-1:0][REG_W-1:0]  mask,
    input  cs_ctrl_t [NUM_CS-1:0]         ctrl,
    input  logic                          boot_mode,
    output logic [NUM_CS-1:0]             sel,
    output logic                          hit,
    output cs_ctrl_t                      sel_ctrl
);

    logic [NUM_CS-1:0] match;

    // Per-line window and refuse-bit check
    for (genvar g = 0; g < NUM_CS; g++) begin : g_match
        logic win_ok, refused, reg_match;
        assign win_ok  = ((addr ^ base[g]) & ~mask[g][ADDR_W-1:0]) == '0;
        assign refused = (write  && mask[g][ADDR_W+MB_NO_WRITE]) ||
                         (!write && mask[g][ADDR_W+MB_NO_READ])  ||
                         (kind == KIND_CPU      && mask[g][ADDR_W+MB_NO_CPU]) ||
                         (kind == KIND_INTERNAL && mask[g][ADDR_W+MB_NO_INT]);
        assign reg_match = ctrl[g].enable && win_ok && !refused;
        if (g == 0) begin : g_boot
            assign match[g] = boot_mode ? (kind == KIND_NORMAL) : reg_match;
        end else begin : g_plain
            assign match[g] = reg_match;
        end
    end

    // Keep only the lowest set match bit
    assign sel = match & (~match + NUM_CS'(1));
    assign hit = |match;

    // Fetch the winner's control fields
    always_comb begin
        sel_ctrl = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (sel[i]) sel_ctrl = ctrl[i];
        end
    end

endmodule

// File: rtl/csc_seq.sv
// Transfer sequencer: drives select, write and hold timing for the
// accepted line. Assumes xfer_done only comes after the start clock.
module csc_seq
    import csc_pkg::*;
#(
    parameter int NUM_CS      = 4,
    parameter int LANE_W      = 4,
    parameter int BURST_BEATS = 4,
    parameter int BEAT_W      = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              write,
    input  logic              burst,
    input  logic [LANE_W-1:0] lanes,
    input  logic              done,
    input  logic [NUM_CS-1:0] sel,
    input  logic              hit,
    input  cs_ctrl_t          sel_ctrl,
    output logic [NUM_CS-1:0] cs_act,
    output logic [LANE_W-1:0] we_act,
    output logic              hold_act
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_BEATS - 1);

    seq_state_e        state, state_nx;
    logic [NUM_CS-1:0] cur_sel;
    logic              cur_write, cur_burst, cur_keep, cur_rd_hold, cur_wr_hold;
    logic [LANE_W-1:0] cur_lanes;
    logic [BEAT_W-1:0] beat_cnt;
    logic              cs_prev;
    logic              accept, last_beat, want_hold;

    assign accept    = (state == ST_IDLE) && start && hit;
    assign last_beat = !cur_burst || (beat_cnt == LAST_BEAT);
    assign want_hold = cur_write ? cur_wr_hold : cur_rd_hold;

    // Next-state choice for beats, gaps and hold
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (accept) state_nx = ST_ACTIVE;
            ST_ACTIVE: if (done) begin
                           if (!last_beat)     state_nx = cur_keep ? ST_ACTIVE : ST_GAP;
                           else if (want_hold) state_nx = ST_HOLD;
                           else                state_nx = ST_IDLE;
                       end
            ST_GAP:    state_nx = ST_ACTIVE;
            ST_HOLD:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Latch the transfer attributes when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sel     <= '0;
            cur_write   <= 1'b0;
            cur_burst   <= 1'b0;
            cur_keep    <= 1'b0;
            cur_rd_hold <= 1'b0;
            cur_wr_hold <= 1'b0;
            cur_lanes   <= '0;
        end else if (accept) begin
            cur_sel     <= sel;
            cur_write   <= write;
            cur_burst   <= burst;
            cur_keep    <= sel_ctrl.keep;
            cur_rd_hold <= sel_ctrl.rd_hold;
            cur_wr_hold <= sel_ctrl.wr_hold;
            cur_lanes   <= lanes;
        end
    end

    // Count terminated beats of the current transfer
    always_ff @(posedge clk) begin
        if (!rst_n)                          beat_cnt <= '0;
        else if (accept)                     beat_cnt <= '0;
        else if (state == ST_ACTIVE && done) beat_cnt <= beat_cnt + BEAT_W'(1);
    end

    // Chip select: start clock without setup, then active and hold clocks
    always_comb begin
        cs_act = '0;
        if (accept && !sel_ctrl.setup)                     cs_act = sel;
        else if (state == ST_ACTIVE || state == ST_HOLD)   cs_act = cur_sel;
    end

    // Remember whether a select was driven in the previous clock
    always_ff @(posedge clk) begin
        if (!rst_n) cs_prev <= 1'b0;
        else        cs_prev <= |cs_act;
    end

    // Write lanes from the second select clock of a write beat
    assign we_act   = (state == ST_ACTIVE && cs_prev && cur_write) ? cur_lanes : '0;
    assign hold_act = (state == ST_HOLD);

endmodule

// File: rtl/chip_select_ctrl.sv
// Chip select controller top: registers, decode and sequencer, with
// active-low outputs forced high during reset. Assumes a single master.
module chip_select_ctrl
    import csc_pkg::*;
#(
    parameter int NUM_CS      = 4,
    parameter int ADDR_W      = 28,
    parameter int LANE_W      = 4,
    parameter int BURST_BEATS = 4,
    localparam int IDX_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int REG_W      = ADDR_W + MB_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        boot_cfg_pins,
    input  logic              xfer_start,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic              xfer_write,
    input  logic [1:0]        xfer_kind,
    input  logic              xfer_burst,
    input  logic [LANE_W-1:0] xfer_lanes,
    input  logic              xfer_done,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [NUM_CS-1:0] cs_n,
    output logic [LANE_W-1:0] we_n,
    output logic              addr_hold,
    output logic [1:0]        boot_port_size,
    output logic              boot_auto_ack
);

    logic [NUM_CS-1:0][ADDR_W-1:0] base;
    logic [NUM_CS-1:0][REG_W-1:0]  mask;
    cs_ctrl_t [NUM_CS-1:0]         ctrl;
    logic                          boot_mode;
    logic [2:0]                    boot_cfg;
    logic [NUM_CS-1:0]             sel, cs_act;
    logic                          hit, hold_act;
    cs_ctrl_t                      sel_ctrl;
    logic [LANE_W-1:0]             we_act;

    csc_regs #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .boot_cfg_pins(boot_cfg_pins),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .base_o(base), .mask_o(mask), .ctrl_o(ctrl),
        .boot_mode_o(boot_mode), .boot_cfg_o(boot_cfg)
    );

    csc_decode #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_decode (
        .addr(xfer_addr), .write(xfer_write), .kind(xfer_kind),
        .base(base), .mask(mask), .ctrl(ctrl), .boot_mode(boot_mode),
        .sel(sel), .hit(hit), .sel_ctrl(sel_ctrl)
    );

    csc_seq #(.NUM_CS(NUM_CS), .LANE_W(LANE_W), .BURST_BEATS(BURST_BEATS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .write(xfer_write),
        .burst(xfer_burst), .lanes(xfer_lanes), .done(xfer_done),
        .sel(sel), .hit(hit), .sel_ctrl(sel_ctrl),
        .cs_act(cs_act), .we_act(we_act), .hold_act(hold_act)
    );

    // Active-low pins, quiet while reset is low
    assign cs_n           = ~(cs_act & {NUM_CS{rst_n}});
    assign we_n           = ~(we_act & {LANE_W{rst_n}});
    assign addr_hold      = hold_act & rst_n;
    assign boot_port_size = boot_cfg[1:0];
    assign boot_auto_ack  = boot_cfg[2];

endmodule

// File: rtl/chip_select_ctrl_chk.sv
// Protocol checker for chip_select_ctrl, attached by bind below.
module chip_select_ctrl_chk #(
    parameter int NUM_CS = 4,
    parameter int LANE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_done,
    input logic [NUM_CS-1:0] cs_n,
    input logic [LANE_W-1:0] we_n,
    input logic              addr_hold
);

    // R1: outputs quiet during reset (checked away from the active edge)
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (cs_n == '1 && we_n == '1 && !addr_hold);
        end
    end

    assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_we_after_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n != '1) |-> ((cs_n != '1) && $past(cs_n != '1)));

    assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hold |-> ((we_n == '1) && (cs_n != '1)));

    assert_hold_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hold |-> $past(xfer_done));

    assert_hold_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hold |=> !addr_hold);

endmodule

bind chip_select_ctrl chip_select_ctrl_chk #(.NUM_CS(NUM_CS), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done),
    .cs_n(cs_n), .we_n(we_n), .addr_hold(addr_hold)
);

// File: tb/chip_select_ctrl_tb.sv
module chip_select_ctrl_tb;

    localparam int NCS = 4;
    localparam int AW  = 16;
    localparam int LW  = 4;
    localparam int NB  = 4;
    localparam int RW  = AW + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_pins = 3'b000;
    logic          st = 1'b0, dn = 1'b0, wr = 1'b0, bu = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [1:0]    kind = 2'b00;
    logic [LW-1:0] lanes = '0;
    logic          rwr = 1'b0, rrd = 1'b0;
    logic [1:0]    ridx = '0, rsel = '0;
    logic [RW-1:0] rwd = '0;
    logic [RW-1:0] rrdata;
    logic [NCS-1:0] cs_n;
    logic [LW-1:0] we_n;
    logic          hold;
    logic [1:0]    psize;
    logic          aack;

    int checks = 0;
    int errors = 0;

    // Shadow of programmed state, kept from the requirements
    logic [AW-1:0] sb_base [NCS];
    logic [RW-1:0] sb_mask [NCS];
    logic [4:0]    sb_ctrl [NCS];
    logic          sb_boot;

    always #10 clk = ~clk;

    chip_select_ctrl #(.NUM_CS(NCS), .ADDR_W(AW), .LANE_W(LW), .BURST_BEATS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .boot_cfg_pins(cfg_pins),
        .xfer_start(st), .xfer_addr(addr), .xfer_write(wr), .xfer_kind(kind),
        .xfer_burst(bu), .xfer_lanes(lanes), .xfer_done(dn),
        .reg_wr(rwr), .reg_rd(rrd), .reg_idx(ridx), .reg_sel(rsel),
        .reg_wdata(rwd), .reg_rdata(rrdata),
        .cs_n(cs_n), .we_n(we_n), .addr_hold(hold),
        .boot_port_size(psize), .boot_auto_ack(aack)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] early, input logic [2:0] last);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_pins = early;
        repeat (3) @(negedge clk);
        cfg_pins = last;             // seen on the final reset edge
        @(negedge clk);
        rst_n = 1'b1;
        cfg_pins = ~last;            // changes after reset must not matter
        for (int i = 0; i < NCS; i++) begin
            sb_base[i] = '0; sb_mask[i] = '0; sb_ctrl[i] = (i == 0) ? 5'h0F : 5'h00;
        end
        sb_boot = 1'b1;
    endtask

    task automatic reg_write(input int idx, input logic [1:0] sel, input logic [RW-1:0] d);
        @(negedge clk);
        rwr = 1'b1; ridx = 2'(idx); rsel = sel; rwd = d;
        @(negedge clk);
        rwr = 1'b0;
        case (sel)
            2'd0: sb_base[idx] = d[AW-1:0];
            2'd1: begin sb_mask[idx] = d; if (idx == 0) sb_boot = 1'b0; end
            default: sb_ctrl[idx] = d[4:0];
        endcase
    endtask

    task automatic reg_check(input int idx, input logic [1:0] sel, input logic [RW-1:0] exp,
                             input string rq);
        @(negedge clk);
        rrd = 1'b1; ridx = 2'(idx); rsel = sel;
        @(negedge clk);
        rrd = 1'b0;
        #2;
        check(rrdata == exp, rq, "register read", 32'(rrdata), 32'(exp));
    endtask

    // One clock: drive start/done, then sample the outputs
    task automatic step(input logic s, input logic d, input int ecs, input bit ewe,
                        input bit ehold, input string rq);
        logic [NCS-1:0] exp_cs;
        logic [LW-1:0]  exp_we;
        @(negedge clk);
        st = s; dn = d;
        #2;
        exp_cs = (ecs >= 0) ? ~(NCS'(1) << ecs) : '1;
        exp_we = ewe ? ~lanes : '1;
        check(cs_n == exp_cs && we_n == exp_we && hold == ehold, rq, "cs_n/we_n/hold",
              {16'h0, 3'b0, hold, exp_we, cs_n}, {16'h0, 3'b0, ehold, exp_we, exp_cs});
    endtask

    function automatic int exp_line(input logic [AW-1:0] a, input logic w, input logic [1:0] k);
        for (int i = 0; i < NCS; i++) begin
            bit m;
            m = sb_ctrl[i][0] && (((a ^ sb_base[i]) & ~sb_mask[i][AW-1:0]) == '0) &&
                !(w && sb_mask[i][AW]) && !(!w && sb_mask[i][AW+1]) &&
                !(k == 2'b01 && sb_mask[i][AW+2]) && !(k == 2'b10 && sb_mask[i][AW+3]);
            if (i == 0 && sb_boot) m = (k == 2'b00);
            if (m) return i;
        end
        return -1;
    endfunction

    // Full transfer with cycle-by-cycle expectation
    task automatic run_xfer(input logic [AW-1:0] a, input logic w, input logic [1:0] k,
                            input logic b, input logic [LW-1:0] ln, input string rq);
        int idx;
        bit su, hl, kp, prev;
        int beats;
        addr = a; wr = w; kind = k; bu = b; lanes = ln;
        idx = exp_line(a, w, k);
        if (idx < 0) begin
            step(1'b1, 1'b0, -1, 0, 0, rq);
            step(1'b0, 1'b1, -1, 0, 0, rq);   // stray terminate ignored
            step(1'b0, 1'b0, -1, 0, 0, rq);
            return;
        end
        su = sb_ctrl[idx][1];
        hl = w ? sb_ctrl[idx][3] : sb_ctrl[idx][2];
        kp = sb_ctrl[idx][4];
        beats = b ? NB : 1;
        step(1'b1, 1'b0, su ? -1 : idx, 0, 0, rq);
        prev = !su;
        for (int bt = 0; bt < beats; bt++) begin
            for (int c = 0; c < 2; c++) begin
                step(1'b0, (c == 1), idx, w && prev, 0, rq);
                prev = 1'b1;
            end
            if (bt != beats - 1 && !kp) begin
                step(1'b0, 1'b0, -1, 0, 0, rq);
                prev = 1'b0;
            end
        end
        if (hl) step(1'b0, 1'b0, idx, 0, 1, rq);
        step(1'b0, 1'b0, -1, 0, 0, rq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        @(negedge clk); #2;
        check(cs_n == '1 && we_n == '1 && !hold, "R1", "outputs in reset",
              {we_n, cs_n}, 8'hFF);
        do_reset(3'b010, 3'b101);
        #2;
        check(cs_n == '1 && we_n == '1 && !hold, "R1", "outputs after reset",
              {we_n, cs_n}, 8'hFF);
        // R10: boot pins from the last reset edge, later changes ignored
        repeat (2) @(negedge clk);
        check(psize == 2'b01 && aack == 1'b1, "R10", "boot config",
              {aack, psize}, 3'b101);
        // R1 / R11: reset register values and read-back
        reg_check(0, 2'd2, RW'(5'h0F), "R1");
        reg_check(1, 2'd2, '0, "R1");
        reg_check(0, 2'd1, '0, "R1");
        reg_check(2, 2'd0, '0, "R1");

        // R8: boot line answers every normal page, never other kinds
        for (int n = 0; n < 16; n++) begin
            for (int k = 0; k < 3; k++) begin
                run_xfer({4'(n), 12'h3A5}, n[0], 2'(k), n[1], 4'(n + 1), "R8");
            end
        end
        // R9: control write keeps boot mode
        reg_write(0, 2'd2, RW'(5'h01));
        reg_check(0, 2'd2, RW'(5'h01), "R11");
        run_xfer(16'h7123, 1'b1, 2'b00, 1'b0, 4'hC, "R9");
        // R9: mask write ends boot mode; page 7 then misses line 0
        reg_write(0, 2'd1, RW'(16'h0FFF));
        reg_check(0, 2'd1, RW'(16'h0FFF), "R11");
        run_xfer(16'h7123, 1'b1, 2'b00, 1'b0, 4'hC, "R9");
        run_xfer(16'h0123, 1'b0, 2'b00, 1'b0, 4'h0, "R9");

        // R2 / R3: overlapping windows with refuse bits, all pages
        reg_write(0, 2'd1, RW'(16'h0FFF) | (RW'(1) << (AW + 1)));
        reg_write(1, 2'd0, RW'(16'h1000));
        reg_write(1, 2'd1, RW'(16'h0FFF));
        reg_write(1, 2'd2, RW'(5'h03));
        reg_write(2, 2'd0, RW'(16'h0000));
        reg_write(2, 2'd1, RW'(16'h1FFF) | (RW'(1) << (AW + 2)));
        reg_write(2, 2'd2, RW'(5'h05));
        reg_write(3, 2'd0, RW'(16'h8000));
        reg_write(3, 2'd1, RW'(16'h7FFF) | (RW'(1) << AW) | (RW'(1) << (AW + 3)));
        reg_write(3, 2'd2, RW'(5'h09));
        reg_check(3, 2'd0, RW'(16'h8000), "R11");
        for (int n = 0; n < 16; n++) begin
            for (int w = 0; w < 2; w++) begin
                for (int k = 0; k < 3; k++) begin
                    run_xfer({4'(n), 12'h5C3}, w[0], 2'(k), 1'b0, 4'(3 * n + w + 1),
                             (n < 2) ? "R3" : "R2");
                end
            end
        end

        // R4 / R5 / R6 / R7: every timing setting on line 1
        for (int c = 0; c < 16; c++) begin
            reg_write(1, 2'd2, RW'({c[3:0], 1'b1}));
            for (int w = 0; w < 2; w++) begin
                for (int b = 0; b < 2; b++) begin
                    string tag;
                    tag = b ? "R7" : (w ? ((c & 4) ? "R6" : "R5") : ((c & 2) ? "R6" : "R4"));
                    run_xfer(16'h1ABC, w[0], 2'b00, b[0], 4'(c + 1), tag);
                end
            end
        end

        // R9: reset restores boot mode; page 7 hits line 0 again
        do_reset(3'b111, 3'b010);
        repeat (2) @(negedge clk);
        check(psize == 2'b10 && aack == 1'b0, "R10", "boot config second reset",
              {aack, psize}, 3'b010);
        run_xfer(16'h7123, 1'b0, 2'b00, 1'b0, 4'h0, "R9");
        run_xfer(16'h7123, 1'b1, 2'b01, 1'b0, 4'hF, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule